// File: doc/BRIEF.md
# Parallel ADC Conversion Read Controller

This block is the host-side sequencer for a 16-bit sampling converter that has a parallel result bus. On a start request it selects the converter and pulses the convert-start line low. It then tracks the converter's busy flag through its rise and fall and fetches the result with the read strobe. The read is either one 16-bit access or two byte accesses over the upper eight data lines. Every pulse width and guard interval is given in nanoseconds. Each one becomes a whole number of system clock cycles, rounded up.

Read activity is kept away from the convert edge on both sides. Before convert-start falls, chip select is held low with the read strobe high for a minimum guard time. After the fall, no read begins until a second guard time has passed and busy has been seen high and then low. The first three completed conversions after reset carry calibration data inside the converter, so they are dropped silently. A watchdog on the busy flag aborts a conversion that never finishes and reports it with a one-cycle error pulse.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is active and immediately after it, cs_n, rd_n and convst_n are 1, and byte_sel, result_valid and busy_timeout are 0.
- R2: When start_req is seen in idle, cs_n goes low with rd_n high for at least ceil(PRE_QUIET_NS/CLK_PERIOD_NS) cycles (5 by default) before convst_n falls, and cs_n is low in the cycle in which convst_n falls.
- R3: convst_n stays low for exactly ceil(CONV_LOW_NS/CLK_PERIOD_NS) cycles (2 by default) per conversion.
- R4: rd_n first goes low no earlier than ceil(POST_QUIET_NS/CLK_PERIOD_NS) cycles (4 by default) after the convst_n fall, and only after busy has been high and has returned low.
- R5: With mode_byte=0 at start, byte_sel stays 0. After the read access time, the full word data_in[15:0] is taken as the result, bit 15 most significant.
- R6: With mode_byte=1 at start, the first access (byte_sel=0) takes data_in[15:8] as result bits 15:8. rd_n then stays low, byte_sel goes to 1, and the second access takes data_in[15:8] as result bits 7:0.
- R7: The first three conversions completed after reset produce no result_valid pulse. Every later completed conversion produces one.
- R8: result_valid is a single-cycle pulse carrying the assembled word on result_data. A start_req that arrives while a conversion or read is in progress is ignored.
- R9: If busy has not both risen and fallen within BUSY_TIMEOUT_CYC cycles of the convst_n fall, busy_timeout pulses for one cycle and the controller returns to idle with cs_n high. No result is reported, and the aborted conversion does not count toward the three discarded ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request one conversion (sampled in idle) |
| mode_byte | input | 1 | 0: one 16-bit read, 1: two byte reads on data_in[15:8] |
| busy | input | 1 | Converter busy flag (asynchronous) |
| data_in | input | 16 | Converter parallel data bus |
| cs_n | output | 1 | Converter chip select, active low |
| rd_n | output | 1 | Converter read strobe, active low |
| convst_n | output | 1 | Converter convert-start, active low |
| byte_sel | output | 1 | Byte select: 0 upper byte / full word, 1 lower byte |
| result_valid | output | 1 | One-cycle pulse: result_data holds a new result |
| result_data | output | 16 | Assembled conversion result |
| busy_timeout | output | 1 | One-cycle pulse: conversion aborted on busy watchdog |

## Verification
The converter model returns the codes 0x0000, 0xFFFF, 0x8000 and 0x7FFF plus mixed patterns. Across word mode and byte mode these tell apart a swapped byte order, a lost half and a read taken from the wrong lane. In byte mode the model drives all ones on the lower lane, so a controller that reads the lower lane instead of the upper one returns a visibly wrong word. A stuck busy flag placed before the warm-up conversions shows whether an aborted conversion is wrongly counted toward the three discarded ones. A start request repeated in the middle of a conversion shows whether an extra conversion is triggered.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CONV,
    ST_POST,
    ST_WAITB,
    ST_RDHI,
    ST_RDLO,
    ST_DONE
  } rd_state_e;

  // nanoseconds to clock cycles, rounded up, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/adc_cnt_timer.sv
module adc_cnt_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_warmup_gate.sv
module adc_warmup_gate #(
  parameter int DISCARD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  output logic warm
);

  localparam int CW = $clog2(DISCARD + 2);

  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  assign warm   = (cnt_q >= CW'(DISCARD));
  assign cnt_en = done & ~warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PH_W    = 4,
  parameter int TMO_W   = 10,
  parameter int PRE_CYC = 5,
  parameter int LOW_CYC = 2,
  parameter int POST_CYC = 4,
  parameter int ACC_CYC = 2,
  parameter int TMO_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              mode_byte,
  input  logic              busy_s,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ph_zero,
  input  logic              tmo_zero,
  input  logic              warm,
  output logic              ph_load,
  output logic [PH_W-1:0]   ph_val,
  output logic              tmo_load,
  output logic [TMO_W-1:0]  tmo_val,
  output logic              tmo_run,
  output logic              cs_n,
  output logic              rd_n,
  output logic              convst_n,
  output logic              byte_sel,
  output logic              done_pulse,
  output logic              result_valid,
  output logic [DATA_W-1:0] result_data,
  output logic              busy_timeout
);

  localparam int HALF = DATA_W / 2;

  rd_state_e         st_q, st_d;
  logic              mode_q;
  logic              seen_q;
  logic              err_q;
  logic [DATA_W-1:0] res_q;
  logic              cap_hi, cap_lo, cap_word;
  logic              to_err;
  logic              in_conv;
  logic              rd_ready;

  assign in_conv  = (st_q == ST_CONV) | (st_q == ST_POST) | (st_q == ST_WAITB);
  assign rd_ready = (st_q == ST_WAITB) & seen_q & ~busy_s;
  assign tmo_run  = in_conv;
  assign tmo_val  = TMO_W'(TMO_CYC - 1);

  // next state
  always_comb begin
    st_d     = st_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    tmo_load = 1'b0;
    cap_hi   = 1'b0;
    cap_lo   = 1'b0;
    cap_word = 1'b0;
    to_err   = 1'b0;
    case (st_q)
      ST_IDLE: if (start_req) begin
        st_d = ST_PRE; ph_load = 1'b1; ph_val = PH_W'(PRE_CYC - 1);
      end
      ST_PRE: if (ph_zero) begin
        st_d = ST_CONV; ph_load = 1'b1; ph_val = PH_W'(LOW_CYC - 1);
        tmo_load = 1'b1;
      end
      ST_CONV: if (ph_zero) begin
        st_d = ST_POST; ph_load = 1'b1; ph_val = PH_W'(POST_CYC - 1);
      end
      ST_POST: if (ph_zero) st_d = ST_WAITB;
      ST_WAITB: if (rd_ready) begin
        st_d = ST_RDHI; ph_load = 1'b1; ph_val = PH_W'(ACC_CYC - 1);
      end
      ST_RDHI: if (ph_zero) begin
        if (mode_q) begin
          cap_hi = 1'b1; st_d = ST_RDLO;
          ph_load = 1'b1; ph_val = PH_W'(ACC_CYC - 1);
        end else begin
          cap_word = 1'b1; st_d = ST_DONE;
        end
      end
      ST_RDLO: if (ph_zero) begin
        cap_lo = 1'b1; st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (in_conv && tmo_zero && !rd_ready && !tmo_load) begin
      st_d   = ST_IDLE;
      to_err = 1'b1;
      ph_load = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= to_err;
      if (st_q == ST_IDLE && start_req) mode_q <= mode_byte;
      if (st_q == ST_IDLE)              seen_q <= 1'b0;
      else if (in_conv && busy_s)       seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else begin
      if (cap_word) res_q <= data_in;
      if (cap_hi)   res_q[DATA_W-1:HALF] <= data_in[DATA_W-1:HALF];
      if (cap_lo)   res_q[HALF-1:0]      <= data_in[DATA_W-1:HALF];
    end
  end

  // pin decode
  assign cs_n         = (st_q == ST_IDLE) | (st_q == ST_DONE);
  assign convst_n     = (st_q != ST_CONV);
  assign rd_n         = ~((st_q == ST_RDHI) | (st_q == ST_RDLO));
  assign byte_sel     = (st_q == ST_RDLO);
  assign done_pulse   = (st_q == ST_DONE);
  assign result_valid = (st_q == ST_DONE) & warm;
  assign result_data  = res_q;
  assign busy_timeout = err_q;

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W           = 16,
  parameter int CLK_PERIOD_NS    = 10,
  parameter int CONV_LOW_NS      = 20,
  parameter int PRE_QUIET_NS     = 50,
  parameter int POST_QUIET_NS    = 40,
  parameter int RD_ACCESS_NS     = 20,
  parameter int BUSY_TIMEOUT_CYC = 1000,
  parameter int DISCARD_CNT      = 3,
  parameter int SYNC_STAGES      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              mode_byte,
  input  logic              busy,
  input  logic [DATA_W-1:0] data_in,
  output logic              cs_n,
  output logic              rd_n,
  output logic              convst_n,
  output logic              byte_sel,
  output logic              result_valid,
  output logic [DATA_W-1:0] result_data,
  output logic              busy_timeout
);

  localparam int LOW_CYC  = ns_to_cyc(CONV_LOW_NS,   CLK_PERIOD_NS);
  localparam int PRE_CYC  = ns_to_cyc(PRE_QUIET_NS,  CLK_PERIOD_NS);
  localparam int POST_CYC = ns_to_cyc(POST_QUIET_NS, CLK_PERIOD_NS);
  localparam int ACC_CYC  = ns_to_cyc(RD_ACCESS_NS,  CLK_PERIOD_NS);
  localparam int PH_MAX   = (PRE_CYC > POST_CYC ? PRE_CYC : POST_CYC) +
                            LOW_CYC + ACC_CYC;
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam int TMO_W    = $clog2(BUSY_TIMEOUT_CYC + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // busy synchronizer
  logic [SYNC_STAGES-1:0] bsync;
  logic                   busy_s;
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_bsync
    logic d;
    if (i == 0) begin : g_first
      assign d = busy;
    end else begin : g_next
      assign d = bsync[i-1];
    end
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) bsync[i] <= 1'b0;
      else         bsync[i] <= d;
    end
  end
  assign busy_s = bsync[SYNC_STAGES-1];

  logic             ph_load, ph_zero;
  logic [PH_W-1:0]  ph_val;
  logic             tmo_load, tmo_run, tmo_zero;
  logic [TMO_W-1:0] tmo_val;
  logic             done_pulse, warm;

  adc_cnt_timer #(.W(PH_W)) u_ph_tmr (
    .clk(clk), .rst_n(rst_ni), .load(ph_load), .load_val(ph_val),
    .run(1'b1), .zero(ph_zero)
  );

  adc_cnt_timer #(.W(TMO_W)) u_tmo_tmr (
    .clk(clk), .rst_n(rst_ni), .load(tmo_load), .load_val(tmo_val),
    .run(tmo_run), .zero(tmo_zero)
  );

  adc_warmup_gate #(.DISCARD(DISCARD_CNT)) u_warm (
    .clk(clk), .rst_n(rst_ni), .done(done_pulse), .warm(warm)
  );

  adc_rd_seq #(
    .DATA_W(DATA_W), .PH_W(PH_W), .TMO_W(TMO_W),
    .PRE_CYC(PRE_CYC), .LOW_CYC(LOW_CYC), .POST_CYC(POST_CYC),
    .ACC_CYC(ACC_CYC), .TMO_CYC(BUSY_TIMEOUT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_ni),
    .start_req(start_req), .mode_byte(mode_byte), .busy_s(busy_s),
    .data_in(data_in), .ph_zero(ph_zero), .tmo_zero(tmo_zero), .warm(warm),
    .ph_load(ph_load), .ph_val(ph_val),
    .tmo_load(tmo_load), .tmo_val(tmo_val), .tmo_run(tmo_run),
    .cs_n(cs_n), .rd_n(rd_n), .convst_n(convst_n), .byte_sel(byte_sel),
    .done_pulse(done_pulse), .result_valid(result_valid),
    .result_data(result_data), .busy_timeout(busy_timeout)
  );

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk
  import adc_rd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int CONV_LOW_NS   = 20,
  parameter int PRE_QUIET_NS  = 50,
  parameter int POST_QUIET_NS = 40
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rd_n,
  input logic convst_n,
  input logic byte_sel,
  input logic busy,
  input logic result_valid,
  input logic busy_timeout
);

  localparam int LOW_CYC  = ns_to_cyc(CONV_LOW_NS,   CLK_PERIOD_NS);
  localparam int PRE_CYC  = ns_to_cyc(PRE_QUIET_NS,  CLK_PERIOD_NS);
  localparam int POST_CYC = ns_to_cyc(POST_QUIET_NS, CLK_PERIOD_NS);

  logic [15:0] low_cnt, rdhi_cnt, since_fall;
  logic        cv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      rdhi_cnt   <= '1;
      since_fall <= '1;
      cv_q       <= 1'b1;
    end else begin
      cv_q    <= convst_n;
      low_cnt <= convst_n ? '0 : low_cnt + 1'b1;
      if (!rd_n)             rdhi_cnt <= '0;
      else if (rdhi_cnt != '1) rdhi_cnt <= rdhi_cnt + 1'b1;
      if (cv_q && !convst_n)   since_fall <= '0;
      else if (since_fall != '1) since_fall <= since_fall + 1'b1;
    end
  end

  a_r2_cs_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n) |-> !cs_n);
  a_r2_pre_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n) |-> (rdhi_cnt >= 16'(PRE_CYC)));
  a_r3_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_n) |-> (low_cnt == 16'(LOW_CYC)));
  a_r4_post_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (since_fall >= 16'(POST_CYC)));
  a_r4_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !busy);
  a_r6_byte_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sel |-> (!rd_n && !cs_n));
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    busy_timeout |=> (!busy_timeout && cs_n));

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .CONV_LOW_NS(CONV_LOW_NS),
  .PRE_QUIET_NS(PRE_QUIET_NS), .POST_QUIET_NS(POST_QUIET_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .convst_n(convst_n),
  .byte_sel(byte_sel), .busy(busy), .result_valid(result_valid),
  .busy_timeout(busy_timeout)
);

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;

  localparam int CLK_NS   = 10;
  // 20 ns, 50 ns, 40 ns at a 10 ns clock, rounded up
  localparam int EXP_LOW  = 2;
  localparam int EXP_PRE  = 5;
  localparam int EXP_POST = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic        mode_byte = 1'b0;
  logic        busy_m;
  logic [15:0] data_in;
  logic        cs_n, rd_n, convst_n, byte_sel, result_valid, busy_timeout;
  logic [15:0] result_data;

  always #(CLK_NS/2) clk = ~clk;

  adc_rd_ctrl u_adc_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .mode_byte(mode_byte),
    .busy(busy_m), .data_in(data_in), .cs_n(cs_n), .rd_n(rd_n),
    .convst_n(convst_n), .byte_sel(byte_sel), .result_valid(result_valid),
    .result_data(result_data), .busy_timeout(busy_timeout)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // converter model
  logic [15:0] held, next_sample;
  logic        conv_prev;
  int          bcnt;
  bit          stuck = 1'b0;
  int          conv_cycles = 12;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 1'b0; conv_prev <= 1'b1; bcnt <= 0; held <= 16'h0;
    end else begin
      conv_prev <= convst_n;
      if (conv_prev && !convst_n) begin
        busy_m <= 1'b1; bcnt <= conv_cycles;
      end else if (busy_m && !stuck) begin
        if (bcnt <= 1) begin busy_m <= 1'b0; held <= next_sample; end
        else bcnt <= bcnt - 1;
      end
    end
  end

  assign data_in = (!cs_n && !rd_n) ? (byte_sel ? {held[7:0], 8'hFF} : held) : 16'hDEAD;

  // protocol monitor and scoreboard
  int  lowlen = 0, last_low = 0, cs_run = 0, cs_at_fall = 0, since_fall = 0;
  int  first_rd = -1;
  bit  cs_low_fall = 0, seen_b = 0, rd_busy_ok = 0, byte_in_word = 0;
  bit  prev_cv = 1, prev_valid = 0, cur_mode = 0;
  int  n_valid = 0, n_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cv && !convst_n) begin
        cs_at_fall = cs_run; cs_low_fall = !cs_n;
        since_fall = 0; first_rd = -1; seen_b = 0;
      end else since_fall++;
      if (!convst_n) lowlen++;
      else if (lowlen > 0) begin last_low = lowlen; lowlen = 0; end
      if (!cs_n && convst_n) cs_run++; else if (cs_n) cs_run = 0;
      if (busy_m) seen_b = 1;
      if (!rd_n && first_rd < 0) begin
        first_rd = since_fall; rd_busy_ok = seen_b && !busy_m;
      end
      if (byte_sel && !cur_mode) byte_in_word = 1;
      if (result_valid) begin
        n_valid++;
        check(!prev_valid, "R8 valid longer than one cycle", 1, 0);
        if (exp_q.size() == 0) check(0, "R7 unexpected result", int'(result_data), 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(result_data == e, cur_mode ? "R6 byte-mode result" : "R5 word-mode result",
                int'(result_data), int'(e));
        end
      end
      if (busy_timeout) n_err++;
      prev_cv = convst_n;
      prev_valid = result_valid;
    end
  end

  task automatic run_conv(input logic [15:0] v, input bit bm, input bit expv, input bit restart);
    int guard;
    cur_mode = bm; byte_in_word = 0; next_sample = v;
    if (expv) exp_q.push_back(v);
    @(negedge clk); start_req = 1'b1; mode_byte = bm;
    @(negedge clk); start_req = 1'b0; mode_byte = 1'b0;
    guard = 0;
    while (cs_n && guard < 50) begin @(negedge clk); guard++; end
    if (restart) begin
      repeat (3) @(negedge clk);
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    end
    guard = 0;
    while (!cs_n && guard < 500) begin @(negedge clk); guard++; end
    repeat (2) @(negedge clk);
    check(last_low == EXP_LOW, "R3 convst_n low width", last_low, EXP_LOW);
    check(cs_low_fall && cs_at_fall >= EXP_PRE, "R2 cs low before convst fall", cs_at_fall, EXP_PRE);
    check(first_rd >= EXP_POST && rd_busy_ok, "R4 read after quiet and busy", first_rd, EXP_POST);
    if (!bm) check(!byte_in_word, "R5 byte_sel held low in word mode", int'(byte_in_word), 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int guard;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(cs_n && rd_n && convst_n && !byte_sel && !result_valid && !busy_timeout,
          "R1 outputs during reset", {cs_n, rd_n, convst_n, byte_sel, result_valid, busy_timeout}, 6'b111000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cs_n && rd_n && convst_n && !byte_sel && !result_valid && !busy_timeout,
          "R1 outputs after reset", {cs_n, rd_n, convst_n, byte_sel, result_valid, busy_timeout}, 6'b111000);

    // R9 busy never falls: abort, error pulse, no count toward warm-up
    stuck = 1'b1; next_sample = 16'hBEEF;
    @(negedge clk); start_req = 1'b1; @(negedge clk); start_req = 1'b0;
    guard = 0;
    while (n_err == 0 && guard < 1500) begin @(negedge clk); guard++; end
    check(n_err == 1, "R9 timeout pulse", n_err, 1);
    @(negedge clk);
    check(cs_n && rd_n, "R9 back to idle", {cs_n, rd_n}, 2'b11);
    stuck = 1'b0;
    repeat (20) @(negedge clk);
    check(n_valid == 0, "R9 no result on timeout", n_valid, 0);

    // R7 three discarded conversions
    run_conv(16'h1111, 1'b0, 1'b0, 1'b0);
    run_conv(16'h2222, 1'b1, 1'b0, 1'b0);
    run_conv(16'h3333, 1'b0, 1'b0, 1'b0);
    check(n_valid == 0, "R7 first three discarded", n_valid, 0);

    // R5 word mode patterns
    run_conv(16'h0000, 1'b0, 1'b1, 1'b0);
    check(n_valid == 1, "R7 fourth conversion reported", n_valid, 1);
    run_conv(16'hFFFF, 1'b0, 1'b1, 1'b0);
    run_conv(16'h8000, 1'b0, 1'b1, 1'b0);
    run_conv(16'h7FFF, 1'b0, 1'b1, 1'b0);
    // R6 byte mode patterns
    run_conv(16'hA55A, 1'b1, 1'b1, 1'b0);
    run_conv(16'h00FF, 1'b1, 1'b1, 1'b0);
    run_conv(16'hFF00, 1'b1, 1'b1, 1'b0);
    // R8 start during conversion ignored
    run_conv(16'h1234, 1'b0, 1'b1, 1'b1);
    guard = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!cs_n) guard++;
    end
    check(guard == 0, "R8 no extra conversion from ignored start", guard, 0);
    check(n_valid == 8, "R8 one result per conversion", n_valid, 8);
    run_conv(16'h5A3C, 1'b1, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 R6 all results delivered", exp_q.size(), 0);
    check(n_err == 1, "R9 no spurious timeout", n_err, 1);
    finish_run();
  end

endmodule